// File: doc/BRIEF.md
# Tiled Texture Address Generator

This block turns a rectangular copy between a plain row-major pixel buffer and a tiled pixel buffer into a stream of byte-address pairs. The tiled buffer is made of 16x16-pixel tiles, each 256 pixels long. Tiles sit side by side along a tile row. Inside a tile, the bits of the pixel coordinates are interleaved and XOR-mixed rather than stored row by row. A data mover consumes the stream, reading at one address and writing at the other. The direction flag chooses which side is read.

A job is started with a one-cycle `start` pulse, which captures the region origin and size, both strides, the pixel size and the direction. The block then issues one pair per accepted valid/ready handshake, in plain source order. It pulses `done` when the walk is over. A job with an unsupported pixel size or with an empty region finishes at once, and the unsupported case also raises `err`.

Top module: `tile_addr_gen`

## Requirements
- R1: The in-tile index, listed from bit 7 down to bit 0, is y[3], x[3]^y[3], y[2], x[2]^y[2], y[1], x[1]^y[1], y[0], x[0]^y[0], where x and y are the low four bits of the absolute pixel coordinates. For example, x=5 and y=10 give index 0xDD.
- R2: The tiled byte address of pixel (x,y) is (y with its low 4 bits cleared) * cfg_tile_stride + bpp * ((x>>4)*256 + index), taken modulo 2^32.
- R3: The linear byte address is row_offset * cfg_lin_stride + bpp * column_offset, modulo 2^32. Both offsets are counted from the region origin.
- R4: Pairs come out in source order: row by row from the top row of the region, and left to right within a row. The first pair is valid in the cycle after the `start` pulse.
- R5: When cfg_load=0 (store), rd_addr is the linear address, wr_addr is the tiled address and rd_is_tiled=0. When cfg_load=1 (load), the two addresses swap and rd_is_tiled=1.
- R6: Only bpp values 1, 2, 3, 4, 6, 8, 12 and 16 are accepted. Any other value at start makes done=1 and err=1 in the next cycle, and no pair is issued.
- R7: A width or height of zero makes done=1 with err=0 in the next cycle, and no pair is issued.
- R8: While out_valid=1 and out_ready=0, the pair and the walk position stay unchanged in the next cycle.
- R9: done is high for exactly one cycle, in the cycle after the last pair is accepted. out_valid is low while done is high.
- R10: A start pulse during a walk or in the done cycle is ignored. The walk continues unchanged and no new job begins.
- R11: After reset, out_valid, done and err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle job launch; the configuration is sampled here |
| cfg_x | input | 13 | Region left column (absolute) |
| cfg_y | input | 13 | Region top row (absolute) |
| cfg_w | input | 13 | Region width in pixels |
| cfg_h | input | 13 | Region height in pixels |
| cfg_lin_stride | input | 32 | Linear buffer row pitch in bytes |
| cfg_tile_stride | input | 32 | Tiled buffer pitch in bytes per pixel row |
| cfg_bpp | input | 5 | Bytes per pixel |
| cfg_load | input | 1 | 0 = store (linear to tiled), 1 = load (tiled to linear) |
| out_valid | output | 1 | An address pair is offered |
| out_ready | input | 1 | The consumer takes the pair |
| rd_addr | output | 32 | Byte address to read |
| wr_addr | output | 32 | Byte address to write |
| rd_is_tiled | output | 1 | High when rd_addr points into the tiled buffer |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | High together with done when the bpp was rejected |

## Verification
The bench targets regions that start in the middle of a tile and cross both tile columns and tile rows. A design that keeps its per-row Y term stale, or that steps the tile-row base at the wrong row, would give tiled addresses that drift after the first row or the first boundary.

Random back-pressure checks that stalled pairs hold still. A design that advances on valid alone would skip or repeat addresses.

Single-pixel, empty and invalid-bpp jobs, together with regions near the top of the coordinate range, test the end of a walk. A design that gets these wrong would issue extra pairs, miss the done pulse, or raise err for a legal pixel size.

Start pulses sent during a walk and in the done cycle must have no effect. A design that re-arms too early would restart the walk or start a second one.

// File: rtl/tile_addr_pkg.sv
// Package: shared widths, walk state type and the pixel-size decoder.
// Assumes the pixel size is always 1 or 3 multiplied by a power of two.
package tile_addr_pkg;

    localparam int COORD_W  = 13;
    localparam int ADDR_W   = 32;
    localparam int BPP_W    = 5;
    localparam int TILE_LOG = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } walk_state_t;

    // A pixel size written as (mul3 ? 3 : 1) << shift, plus a legality bit.
    typedef struct packed {
        logic       ok;
        logic       mul3;
        logic [2:0] shift;
    } bpp_code_t;

    function automatic bpp_code_t decode_bpp(input logic [BPP_W-1:0] b);
        bpp_code_t c;
        c = '{ok: 1'b1, mul3: 1'b0, shift: 3'd0};
        case (b)
            5'd1:    c.shift = 3'd0;
            5'd2:    c.shift = 3'd1;
            5'd3:    c.mul3  = 1'b1;
            5'd4:    c.shift = 3'd2;
            5'd6:    begin c.mul3 = 1'b1; c.shift = 3'd1; end
            5'd8:    c.shift = 3'd3;
            5'd12:   begin c.mul3 = 1'b1; c.shift = 3'd2; end
            5'd16:   c.shift = 3'd4;
            default: c.ok = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tile_bit_expand.sv
// Module: widens a BITS-wide value to 2*BITS bits.
// DUP=1 copies each bit into both positions of its pair.
// DUP=0 places each bit in the even position and puts zero in the odd one.
// Assumes nothing; purely combinational.
module tile_bit_expand #(
    parameter int BITS = 4,
    parameter bit DUP  = 1'b1
) (
    input  logic [BITS-1:0]   in_bits,
    output logic [2*BITS-1:0] out_bits
);
    // Route each input bit to its pair of output bits.
    for (genvar i = 0; i < BITS; i++) begin : g_pair
        assign out_bits[2*i] = in_bits[i];
        if (DUP) begin : g_dup
            assign out_bits[2*i+1] = in_bits[i];
        end else begin : g_gap
            assign out_bits[2*i+1] = 1'b0;
        end
    end
endmodule

// File: rtl/tile_bpp_scale.sv
// Module: multiplies a pixel count by a pixel size given as (1 or 3) << shift.
// Uses one add and one shift, with no general multiplier.
// Assumes the result fits in OUT_W bits, or that wrapping modulo 2^OUT_W is acceptable.
module tile_bpp_scale #(
    parameter int IN_W  = 17,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  in_val,
    input  logic             mul3,
    input  logic [2:0]       shift,
    output logic [OUT_W-1:0] out_val
);
    logic [OUT_W-1:0] base;
    logic [OUT_W-1:0] tripled;

    // Optional times-three step, then the power-of-two shift.
    always_comb begin
        base    = OUT_W'(in_val);
        tripled = mul3 ? (base + (base << 1)) : base;
        out_val = tripled << shift;
    end
endmodule

// File: rtl/tile_walk_ctrl.sv
// Module: job sequencer. It captures the configuration on start, walks the region
// in source order under the valid/ready handshake, and holds the per-row terms:
// the doubled-Y pattern, the tiled row base and the linear row base.
// Assumes cfg_x + cfg_w and cfg_y + cfg_h do not exceed 2^COORD_W.
module tile_walk_ctrl
    import tile_addr_pkg::*;
#(
    parameter int CW       = COORD_W,
    parameter int AW       = ADDR_W,
    parameter int BW       = BPP_W,
    parameter int TLOG     = TILE_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CW-1:0]     cfg_x,
    input  logic [CW-1:0]     cfg_y,
    input  logic [CW-1:0]     cfg_w,
    input  logic [CW-1:0]     cfg_h,
    input  logic [AW-1:0]     cfg_lin_stride,
    input  logic [AW-1:0]     cfg_tile_stride,
    input  logic [BW-1:0]     cfg_bpp,
    input  logic              cfg_load,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              done,
    output logic              err,
    output logic [CW-1:0]     cur_x,
    output logic [CW-1:0]     cur_y,
    output logic [2*TLOG-1:0] ydup,
    output logic [AW-1:0]     lin_addr,
    output logic [AW-1:0]     tile_row_base,
    output logic              bpp_mul3,
    output logic [2:0]        bpp_shift,
    output logic              role_load
);
    walk_state_t      state;
    bpp_code_t        code_in, code_r;
    logic [CW-1:0]    x0_r, w_r, h_r, sx, sy, cx, cy, cy_nxt;
    logic [AW-1:0]    lstride_r, tstride_r, lin_row, lin_col, tile_row_init;
    logic [BW-1:0]    bpp_r;
    logic             err_r, load_r, row_end, last_px;
    logic [TLOG-1:0]  ylo_sel;
    logic [2*TLOG-1:0] ydup_nxt, ydup_r;

    // Decode the offered pixel size and prepare the start-time row terms.
    always_comb begin
        code_in       = decode_bpp(cfg_bpp);
        cy_nxt        = cy + CW'(1);
        ylo_sel       = (state == ST_IDLE) ? cfg_y[TLOG-1:0] : cy_nxt[TLOG-1:0];
        tile_row_init = AW'({cfg_y[CW-1:TLOG], {TLOG{1'b0}}}) * cfg_tile_stride;
        row_end       = (sx == w_r - CW'(1));
        last_px       = row_end && (sy == h_r - CW'(1));
    end

    tile_bit_expand #(.BITS(TLOG), .DUP(1'b1)) u_ydup (
        .in_bits (ylo_sel),
        .out_bits(ydup_nxt)
    );

    // Sequencer and region counters; they move only on an accepted pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            code_r    <= '0;
            x0_r      <= '0;
            w_r       <= '0;
            h_r       <= '0;
            sx        <= '0;
            sy        <= '0;
            cx        <= '0;
            cy        <= '0;
            lstride_r <= '0;
            tstride_r <= '0;
            bpp_r     <= '0;
            lin_row   <= '0;
            lin_col   <= '0;
            tile_row_base <= '0;
            ydup_r    <= '0;
            err_r     <= 1'b0;
            load_r    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        code_r        <= code_in;
                        x0_r          <= cfg_x;
                        w_r           <= cfg_w;
                        h_r           <= cfg_h;
                        lstride_r     <= cfg_lin_stride;
                        tstride_r     <= cfg_tile_stride;
                        bpp_r         <= cfg_bpp;
                        load_r        <= cfg_load;
                        sx            <= '0;
                        sy            <= '0;
                        cx            <= cfg_x;
                        cy            <= cfg_y;
                        ydup_r        <= ydup_nxt;
                        lin_row       <= '0;
                        lin_col       <= '0;
                        tile_row_base <= tile_row_init;
                        err_r         <= !code_in.ok;
                        if (!code_in.ok || cfg_w == '0 || cfg_h == '0) begin
                            state <= ST_FIN;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (out_ready) begin
                        if (last_px) begin
                            state <= ST_FIN;
                        end else if (row_end) begin
                            sx      <= '0;
                            cx      <= x0_r;
                            sy      <= sy + CW'(1);
                            cy      <= cy_nxt;
                            ydup_r  <= ydup_nxt;
                            lin_row <= lin_row + lstride_r;
                            lin_col <= '0;
                            if (cy_nxt[TLOG-1:0] == '0) begin
                                tile_row_base <= tile_row_base + (tstride_r << TLOG);
                            end
                        end else begin
                            sx      <= sx + CW'(1);
                            cx      <= cx + CW'(1);
                            lin_col <= lin_col + AW'(bpp_r);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the outputs from the held state.
    always_comb begin
        out_valid = (state == ST_RUN);
        done      = (state == ST_FIN);
        err       = (state == ST_FIN) && err_r;
        cur_x     = cx;
        cur_y     = cy;
        ydup      = ydup_r;
        lin_addr  = lin_row + lin_col;
        bpp_mul3  = code_r.mul3;
        bpp_shift = code_r.shift;
        role_load = load_r;
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    bad_bpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !code_in.ok) |=> (done && err && !out_valid));

    // R7
    empty_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && code_in.ok && (cfg_w == '0 || cfg_h == '0))
        |=> (done && !err && !out_valid));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && start) |=> (out_valid && $stable(cx) && $stable(cy)));
endmodule

// File: rtl/tile_addr_gen.sv
// Module: top of the tiled texture address generator. It combines the held
// row terms from the sequencer with the per-pixel spaced-X term to form the
// in-tile index. From that it builds the tiled and linear byte addresses and
// routes them to the read and write sides according to the direction.
// Assumes the consumer follows valid/ready and pulses start only when idle.
module tile_addr_gen
    import tile_addr_pkg::*;
#(
    parameter int CW   = COORD_W,
    parameter int AW   = ADDR_W,
    parameter int BW   = BPP_W,
    parameter int TLOG = TILE_LOG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cfg_x,
    input  logic [CW-1:0] cfg_y,
    input  logic [CW-1:0] cfg_w,
    input  logic [CW-1:0] cfg_h,
    input  logic [AW-1:0] cfg_lin_stride,
    input  logic [AW-1:0] cfg_tile_stride,
    input  logic [BW-1:0] cfg_bpp,
    input  logic          cfg_load,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic          rd_is_tiled,
    output logic          done,
    output logic          err
);
    localparam int IDX_W  = 2 * TLOG;
    localparam int ELEM_W = CW + TLOG;

    logic [CW-1:0]     cur_x, cur_y;
    logic [IDX_W-1:0]  ydup, xspread, swz_idx;
    logic [AW-1:0]     lin_addr, tile_row_base, tile_off, tile_addr;
    logic [ELEM_W-1:0] elem;
    logic              bpp_mul3, role_load;
    logic [2:0]        bpp_shift;

    tile_walk_ctrl #(.CW(CW), .AW(AW), .BW(BW), .TLOG(TLOG)) u_walk (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .cfg_x          (cfg_x),
        .cfg_y          (cfg_y),
        .cfg_w          (cfg_w),
        .cfg_h          (cfg_h),
        .cfg_lin_stride (cfg_lin_stride),
        .cfg_tile_stride(cfg_tile_stride),
        .cfg_bpp        (cfg_bpp),
        .cfg_load       (cfg_load),
        .out_ready      (out_ready),
        .out_valid      (out_valid),
        .done           (done),
        .err            (err),
        .cur_x          (cur_x),
        .cur_y          (cur_y),
        .ydup           (ydup),
        .lin_addr       (lin_addr),
        .tile_row_base  (tile_row_base),
        .bpp_mul3       (bpp_mul3),
        .bpp_shift      (bpp_shift),
        .role_load      (role_load)
    );

    tile_bit_expand #(.BITS(TLOG), .DUP(1'b0)) u_xspread (
        .in_bits (cur_x[TLOG-1:0]),
        .out_bits(xspread)
    );

    // In-tile index and element number along the tile row.
    always_comb begin
        swz_idx = ydup ^ xspread;
        elem    = {cur_x[CW-1:TLOG], swz_idx};
    end

    tile_bpp_scale #(.IN_W(ELEM_W), .OUT_W(AW)) u_scale (
        .in_val (elem),
        .mul3   (bpp_mul3),
        .shift  (bpp_shift),
        .out_val(tile_off)
    );

    // Final tiled address and the role routing.
    always_comb begin
        tile_addr   = tile_row_base + tile_off;
        rd_addr     = role_load ? tile_addr : lin_addr;
        wr_addr     = role_load ? lin_addr  : tile_addr;
        rd_is_tiled = role_load;
    end

    // R1
    swizzle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (swz_idx == {cur_y[3], cur_x[3] ^ cur_y[3], cur_y[2], cur_x[2] ^ cur_y[2],
                                   cur_y[1], cur_x[1] ^ cur_y[1], cur_y[0], cur_x[0] ^ cur_y[0]}));

    // R8
    hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(rd_addr) && $stable(wr_addr)));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);
endmodule

// File: tb/tile_addr_gen_test.sv
module tile_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [12:0] cfg_x, cfg_y, cfg_w, cfg_h;
    logic [31:0] cfg_lin_stride, cfg_tile_stride;
    logic [4:0]  cfg_bpp;
    logic        cfg_load;
    logic        out_valid, out_ready;
    logic [31:0] rd_addr, wr_addr;
    logic        rd_is_tiled, done, err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] first_wr;

    always #5 clk = ~clk;

    tile_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_x(cfg_x), .cfg_y(cfg_y), .cfg_w(cfg_w), .cfg_h(cfg_h),
        .cfg_lin_stride(cfg_lin_stride), .cfg_tile_stride(cfg_tile_stride),
        .cfg_bpp(cfg_bpp), .cfg_load(cfg_load),
        .out_valid(out_valid), .out_ready(out_ready),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .rd_is_tiled(rd_is_tiled),
        .done(done), .err(err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_index(input int x, input int y);
        logic [7:0] r;
        for (int i = 0; i < 4; i++) begin
            r[2*i+1] = y[i];
            r[2*i]   = x[i] ^ y[i];
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_tiled(input int x, input int y, input logic [31:0] ts, input int bpp);
        logic [31:0] row, px;
        row = 32'(y & ~15) * ts;
        px  = 32'(bpp) * (32'((x >> 4) * 256) + 32'(ref_index(x, y)));
        return row + px;
    endfunction

    function automatic bit legal_bpp(input int b);
        return (b == 1 || b == 2 || b == 3 || b == 4 || b == 6 || b == 8 || b == 12 || b == 16);
    endfunction

    task automatic run_job(input int x0, input int y0, input int w, input int h,
                           input logic [31:0] ls, input logic [31:0] ts, input int bpp,
                           input bit load, input bit stall, input bit poke);
        int total, k, guard, sx, sy;
        bit poked, stalled;
        logic [31:0] et, el;
        @(negedge clk);
        cfg_x = 13'(x0); cfg_y = 13'(y0); cfg_w = 13'(w); cfg_h = 13'(h);
        cfg_lin_stride = ls; cfg_tile_stride = ts; cfg_bpp = 5'(bpp); cfg_load = load;
        start = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        cfg_x = cfg_x + 13'd7; cfg_bpp = 5'd5; cfg_load = ~load;
        if (!legal_bpp(bpp) || w == 0 || h == 0) begin
            check(legal_bpp(bpp) ? "R7" : "R6", "done after start", 32'(done), 32'd1);
            check(legal_bpp(bpp) ? "R7" : "R6", "err after start", 32'(err), legal_bpp(bpp) ? 32'd0 : 32'd1);
            check(legal_bpp(bpp) ? "R7" : "R6", "no pair issued", 32'(out_valid), 32'd0);
            @(negedge clk);
            check("R9", "done is a single pulse", 32'(done), 32'd0);
            return;
        end
        total = w * h; k = 0; guard = 0; poked = 0; stalled = 0;
        forever begin
            if (done) begin
                check("R9", "done right after last pair", 32'(k), 32'(total));
                check("R6", "no err on legal bpp", 32'(err), 32'd0);
                check("R9", "valid low in done cycle", 32'(out_valid), 32'd0);
                break;
            end
            check("R4", "pair offered during walk", 32'(out_valid), 32'd1);
            if (k >= total) begin
                check("R4", "no extra pairs", 32'(k), 32'(total - 1));
                break;
            end
            sy = k / w; sx = k % w;
            et = ref_tiled(x0 + sx, y0 + sy, ts, bpp);
            el = 32'(sy) * ls + 32'(bpp) * 32'(sx);
            if (k == 0) first_wr = wr_addr;
            check(stalled ? "R8" : "R2", "tiled address", load ? rd_addr : wr_addr, et);
            check(stalled ? "R8" : "R3", "linear address", load ? wr_addr : rd_addr, el);
            check("R5", "role tag", 32'(rd_is_tiled), 32'(load));
            if (poke && k == 1 && !poked) begin
                start = 1'b1; cfg_x = 13'd0; cfg_w = 13'd3; cfg_bpp = 5'd4; poked = 1;
            end else begin
                start = 1'b0;
            end
            out_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
            stalled = !out_ready;
            if (out_ready) k++;
            @(negedge clk);
            guard++;
            if (guard > 20000) begin
                check("R9", "job finished", 32'(guard), 32'd0);
                break;
            end
        end
        out_ready = 1'b0;
        if (poke) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R10", "start in done cycle ignored (valid)", 32'(out_valid), 32'd0);
            check("R10", "start in done cycle ignored (done)", 32'(done), 32'd0);
        end else begin
            @(negedge clk);
            check("R9", "done is a single pulse", 32'(done), 32'd0);
        end
    endtask

    initial begin
        int bpps[8];
        bpps = '{1, 2, 3, 4, 6, 8, 12, 16};
        void'($urandom(32'd4242));
        rst_n = 1'b0; start = 1'b0; out_ready = 1'b0;
        cfg_x = '0; cfg_y = '0; cfg_w = '0; cfg_h = '0;
        cfg_lin_stride = '0; cfg_tile_stride = '0; cfg_bpp = '0; cfg_load = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "valid after reset", 32'(out_valid), 32'd0);
        check("R11", "done after reset", 32'(done), 32'd0);
        check("R11", "err after reset", 32'(err), 32'd0);

        // R1: single pixel at x=5, y=10, bpp 1, zero pitch -> index 0xDD
        run_job(5, 10, 1, 1, 32'd64, 32'd0, 1, 1'b0, 1'b0, 1'b0);
        check("R1", "index of (5,10)", first_wr, 32'h0000_00DD);
        // R1/R2: one full tile, store and load
        run_job(0, 0, 16, 16, 32'd64, 32'd0, 1, 1'b0, 1'b0, 1'b0);
        run_job(16, 32, 16, 16, 32'd256, 32'd1024, 4, 1'b1, 1'b1, 1'b0);
        // R2/R4: unaligned region crossing tile columns and a tile row
        run_job(13, 14, 22, 5, 32'd200, 32'd4096, 3, 1'b0, 1'b1, 1'b0);
        // near the top of the coordinate range
        run_job(8180, 8185, 10, 6, 32'd40, 32'h0010_0000, 16, 1'b1, 1'b0, 1'b0);
        // R10: start pulses during walk and in done cycle
        run_job(7, 3, 6, 4, 32'd48, 32'd512, 12, 1'b0, 1'b1, 1'b1);
        // R6: illegal sizes
        run_job(0, 0, 4, 4, 32'd16, 32'd16, 0, 1'b0, 1'b0, 1'b0);
        run_job(0, 0, 4, 4, 32'd16, 32'd16, 5, 1'b1, 1'b0, 1'b0);
        run_job(0, 0, 4, 4, 32'd16, 32'd16, 31, 1'b0, 1'b0, 1'b0);
        // R7: empty regions
        run_job(3, 3, 0, 5, 32'd16, 32'd16, 4, 1'b0, 1'b0, 1'b0);
        run_job(3, 3, 5, 0, 32'd16, 32'd16, 4, 1'b1, 1'b0, 1'b0);

        for (int j = 0; j < 40; j++) begin
            run_job(int'($urandom_range(0, 400)), int'($urandom_range(0, 400)),
                    int'($urandom_range(1, 24)), int'($urandom_range(1, 20)),
                    $urandom(), $urandom(), bpps[$urandom_range(0, 7)],
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule